// File: doc/BRIEF.md
# Port Flush Table Walker

This block clears learned address associations from a switch's address table for a chosen set of ports. A single start pulse, together with a per-port flush mask, launches a walk that visits every table index in ascending order over a single-port table RAM interface. Each entry is classified from its own type field. Address entries are rewritten according to whether they are unicast or multicast. All other entries are passed over without a write.

Unicast address entries whose owning port is selected are released whole. Multicast address entries lose only the selected ports from their membership mask. Such an entry is released when the host port is its sole remaining member. The host port is the highest-numbered port, so its mask bit sits at the position equal to the number of external ports. The RAM has a one-cycle read latency. Because the multicast membership field reaches bit 68, the table word is 69 bits wide in the default configuration. When the walk is over, the block pulses done for one cycle.

Top module: `port_flush_walker`

## Requirements
- R1: After reset the block is idle: busy_o and done_o are low and the table port is not enabled.
- R2: An accepted start walks indices 0 to DEPTH-1 in ascending order. Each index gets one read cycle followed by one evaluation cycle in which the table port is idle.
- R3: An entry whose type field (bits 61:60) is 0 or 2 receives no write. Only type 1 (address) and type 3 (address with VLAN) entries are processed.
- R4: Every address entry is written back exactly once, to the same index, in the cycle after its evaluation cycle, whether or not it changed. The next read follows that write.
- R5: A unicast address entry (bit 40 clear) has its owner port number in bits 67:66. If the flush mask bit for that port is set, the type field becomes 0 and every other bit is kept.
- R6: A multicast address entry (bit 40 set) has its membership mask in bits 68:66. If that mask shares no bit with the flush mask, the entry is written back unchanged.
- R7: For an intersecting multicast entry, the flushed ports are cleared from its mask. If the remaining mask is exactly the host-port bit (bit EXT_PORTS), the type field becomes 0. A remaining mask of zero leaves the type as it was.
- R8: With an all-zero flush mask the full walk and all write-backs still take place, and no entry changes.
- R9: done_o is high for exactly one cycle, the cycle after the last entry's final access. busy_o is high from the cycle after start through the done cycle.
- R10: start_i is ignored while busy_o is high. The flush mask is sampled only in the cycle a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| flush_mask_i | input | EXT_PORTS+1 | Ports to flush; the top bit is the host port |
| busy_o | output | 1 | Walk in progress, including the done cycle |
| done_o | output | 1 | One-cycle pulse at the end of the walk |
| tbl_en_o | output | 1 | Table access enable |
| tbl_we_o | output | 1 | Table write enable (qualified by tbl_en_o) |
| tbl_addr_o | output | $clog2(DEPTH) | Table index |
| tbl_wdata_o | output | 66+EXT_PORTS+1 | Entry written back |
| tbl_rdata_i | input | 66+EXT_PORTS+1 | Entry read, valid the cycle after a read |

## Verification
The hardest case to reach is the multicast boundary between release and retention. An entry must be freed when only the host bit remains. It must keep its type when the flush removes every port, host included, and leaves an empty mask. The stimulus preloads the bench RAM with multicast entries whose masks are chosen against each flush mask: one leaves exactly the host bit, one leaves an external port, one becomes empty and one does not intersect. The same table is then walked under several flush masks, including all-zero and all-ones. One walk also receives a second start and a changed flush mask partway through, to show that neither is taken.

// File: rtl/pfw_pkg.sv
package pfw_pkg;

    // Field positions inside a table entry; these are decoded by neighbours.
    localparam int TYPE_LSB     = 60;
    localparam int TYPE_W       = 2;
    localparam int MC_BIT       = 40;
    localparam int PORT_FLD_LSB = 66;

    typedef enum logic [1:0] {
        ET_FREE      = 2'd0,
        ET_ADDR      = 2'd1,
        ET_VLAN      = 2'd2,
        ET_VLAN_ADDR = 2'd3
    } ent_type_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_EVAL  = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4
    } walk_st_e;

endpackage

// File: rtl/pfw_entry_rule.sv
module pfw_entry_rule
    import pfw_pkg::*;
#(
    parameter int EXT_PORTS = 2,
    parameter int NUM_PORTS = EXT_PORTS + 1,
    parameter int PNUM_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    parameter int ENTRY_W   = PORT_FLD_LSB + NUM_PORTS
) (
    input  logic [ENTRY_W-1:0]   ent_i,
    input  logic [NUM_PORTS-1:0] flush_i,
    output logic [ENTRY_W-1:0]   ent_o,
    output logic                 is_addr_o
);

    localparam logic [NUM_PORTS-1:0] HOST_BIT = NUM_PORTS'(1) << EXT_PORTS;

    ent_type_e               ent_type;
    logic                    is_mcast;
    logic [NUM_PORTS-1:0]    member_mask;
    logic [NUM_PORTS-1:0]    remain_mask;
    logic [PNUM_W-1:0]       owner_port;
    logic [NUM_PORTS-1:0]    owner_hit_vec;
    logic                    owner_hit;
    logic                    member_hit;
    logic                    host_only;

    assign ent_type    = ent_type_e'(ent_i[TYPE_LSB +: TYPE_W]);
    assign is_addr_o   = (ent_type == ET_ADDR) || (ent_type == ET_VLAN_ADDR);
    assign is_mcast    = ent_i[MC_BIT];
    assign member_mask = ent_i[PORT_FLD_LSB +: NUM_PORTS];
    assign owner_port  = ent_i[PORT_FLD_LSB +: PNUM_W];
    assign remain_mask = member_mask & ~flush_i;
    assign member_hit  = |(member_mask & flush_i);
    assign host_only   = (remain_mask == HOST_BIT);

    // One comparator per port: owner number matches and that port is flushed.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_owner
        assign owner_hit_vec[p] = flush_i[p] && (owner_port == PNUM_W'(p));
    end
    assign owner_hit = |owner_hit_vec;

    always_comb begin
        ent_o = ent_i;
        if (is_addr_o) begin
            if (is_mcast) begin
                if (member_hit) begin
                    ent_o[PORT_FLD_LSB +: NUM_PORTS] = remain_mask;
                    if (host_only) begin
                        ent_o[TYPE_LSB +: TYPE_W] = ET_FREE;
                    end
                end
            end else if (owner_hit) begin
                ent_o[TYPE_LSB +: TYPE_W] = ET_FREE;
            end
        end
    end

endmodule

// File: rtl/pfw_sequencer.sv
module pfw_sequencer
    import pfw_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              is_addr_i,
    output walk_st_e          state_o,
    output logic [ADDR_W-1:0] idx_o
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;
    logic at_last;

    assign at_last = (seq_q.idx == LAST_IDX);

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st  = ST_READ;
                    seq_d.idx = '0;
                end
            end
            ST_READ: begin
                seq_d.st = ST_EVAL;
            end
            ST_EVAL: begin
                if (is_addr_i) begin
                    seq_d.st = ST_WRITE;
                end else if (at_last) begin
                    seq_d.st = ST_DONE;
                end else begin
                    seq_d.st  = ST_READ;
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            ST_WRITE: begin
                if (at_last) begin
                    seq_d.st = ST_DONE;
                end else begin
                    seq_d.st  = ST_READ;
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            ST_DONE: begin
                seq_d.st = ST_IDLE;
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st  <= ST_IDLE;
            seq_q.idx <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o = seq_q.st;
    assign idx_o   = seq_q.idx;

endmodule

// File: rtl/port_flush_walker.sv
module port_flush_walker
    import pfw_pkg::*;
#(
    parameter int EXT_PORTS = 2,
    parameter int DEPTH     = 16,
    parameter int NUM_PORTS = EXT_PORTS + 1,
    parameter int ADDR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int ENTRY_W   = PORT_FLD_LSB + NUM_PORTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NUM_PORTS-1:0] flush_mask_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 tbl_en_o,
    output logic                 tbl_we_o,
    output logic [ADDR_W-1:0]    tbl_addr_o,
    output logic [ENTRY_W-1:0]   tbl_wdata_o,
    input  logic [ENTRY_W-1:0]   tbl_rdata_i
);

    typedef struct packed {
        logic [NUM_PORTS-1:0] flush;
        logic [ENTRY_W-1:0]   ent;
    } dp_t;

    dp_t                 dp_d, dp_q;
    walk_st_e            state;
    logic [ADDR_W-1:0]   idx;
    logic [ENTRY_W-1:0]  rule_out;
    logic                rule_is_addr;

    pfw_sequencer #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .is_addr_i (rule_is_addr),
        .state_o   (state),
        .idx_o     (idx)
    );

    pfw_entry_rule #(
        .EXT_PORTS (EXT_PORTS),
        .NUM_PORTS (NUM_PORTS),
        .ENTRY_W   (ENTRY_W)
    ) u_rule (
        .ent_i     (tbl_rdata_i),
        .flush_i   (dp_q.flush),
        .ent_o     (rule_out),
        .is_addr_o (rule_is_addr)
    );

    always_comb begin
        dp_d = dp_q;
        if (state == ST_IDLE && start_i) begin
            dp_d.flush = flush_mask_i;
        end
        if (state == ST_EVAL) begin
            dp_d.ent = rule_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign busy_o      = (state != ST_IDLE);
    assign done_o      = (state == ST_DONE);
    assign tbl_en_o    = (state == ST_READ) || (state == ST_WRITE);
    assign tbl_we_o    = (state == ST_WRITE);
    assign tbl_addr_o  = idx;
    assign tbl_wdata_o = dp_q.ent;

endmodule

// File: rtl/port_flush_walker_chk.sv
module port_flush_walker_chk #(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 4,
    parameter int ENTRY_W   = 69
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy_o,
    input logic               done_o,
    input logic               tbl_en_o,
    input logic               tbl_we_o,
    input logic [ADDR_W-1:0]  tbl_addr_o,
    input logic [ENTRY_W-1:0] tbl_wdata_o,
    input logic [ENTRY_W-1:0] tbl_rdata_i
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !tbl_en_o); // R1
    AST_WRITE_ONLY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_en_o && tbl_we_o) |-> $past(tbl_rdata_i[60])); // R3
    AST_WRITE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_en_o && tbl_we_o) |-> !$past(tbl_en_o)); // R4
    AST_WRITE_SAME_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_en_o && tbl_we_o) |-> (tbl_addr_o == $past(tbl_addr_o, 2))); // R4
    AST_KEEP_OTHER_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_en_o && tbl_we_o) |-> (tbl_wdata_o[59:0] == $past(tbl_rdata_i[59:0])
                                 && tbl_wdata_o[65:62] == $past(tbl_rdata_i[65:62]))); // R5
    AST_TYPE_KEEP_OR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_en_o && tbl_we_o) |-> (tbl_wdata_o[61:60] == $past(tbl_rdata_i[61:60])
                                 || tbl_wdata_o[61:60] == 2'd0)); // R5
    AST_MASK_ONLY_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_en_o && tbl_we_o && $past(tbl_rdata_i[40])) |->
        ((tbl_wdata_o[ENTRY_W-1:66] & ~$past(tbl_rdata_i[ENTRY_W-1:66])) == '0)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_o && !tbl_en_o)); // R9

endmodule

bind port_flush_walker port_flush_walker_chk #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W),
    .ENTRY_W   (ENTRY_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .tbl_en_o    (tbl_en_o),
    .tbl_we_o    (tbl_we_o),
    .tbl_addr_o  (tbl_addr_o),
    .tbl_wdata_o (tbl_wdata_o),
    .tbl_rdata_i (tbl_rdata_i)
);

// File: tb/port_flush_walker_test.sv
module port_flush_walker_test;

    localparam int EXT   = 2;
    localparam int NP    = 3;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int EW    = 69;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [NP-1:0] flush_mask_i = '0;
    logic          busy_o, done_o, tbl_en_o, tbl_we_o;
    logic [AW-1:0] tbl_addr_o;
    logic [EW-1:0] tbl_wdata_o;
    logic [EW-1:0] rd_q = '0;

    logic [EW-1:0] mem     [DEPTH];
    logic [EW-1:0] exp_mem [DEPTH];

    int vectors = 0;
    int fails   = 0;

    typedef struct {
        bit            en;
        bit            we;
        int            addr;
        logic [EW-1:0] wd;
        bit            done;
        bit            busy;
        string         tag;
    } ev_t;
    ev_t evq[$];

    always #10 clk = ~clk;

    port_flush_walker uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .flush_mask_i (flush_mask_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .tbl_en_o     (tbl_en_o),
        .tbl_we_o     (tbl_we_o),
        .tbl_addr_o   (tbl_addr_o),
        .tbl_wdata_o  (tbl_wdata_o),
        .tbl_rdata_i  (rd_q)
    );

    // Bench table RAM: one-cycle read latency.
    always @(posedge clk) begin
        if (tbl_en_o) begin
            if (tbl_we_o) mem[tbl_addr_o] <= tbl_wdata_o;
            else          rd_q <= mem[tbl_addr_o];
        end
    end

    task automatic check(string tag, string what, logic [EW-1:0] act, logic [EW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [EW-1:0] mk(int typ, bit mc, int fld, int low);
        logic [EW-1:0] e;
        e = '0;
        e[31:0]  = 32'(low);
        e[47:41] = 7'(low * 3);
        e[59:48] = 12'(low + 5);
        e[61:60] = 2'(typ);
        e[40]    = mc;
        e[68:66] = 3'(fld);
        return e;
    endfunction

    // Behavioural expectation of one entry after a flush.
    function automatic logic [EW-1:0] expect_entry(logic [EW-1:0] e, int fm);
        logic [EW-1:0] r;
        int typ, m, m2, p;
        r   = e;
        typ = int'(e[61:60]);
        if (typ != 1 && typ != 3) return r;
        if (e[40]) begin
            m = int'(e[68:66]);
            if ((m & fm) == 0) return r;
            m2 = m & ~fm & 7;
            r[68:66] = 3'(m2);
            if (m2 == (1 << EXT)) r[61:60] = 2'd0;
        end else begin
            p = int'(e[67:66]);
            if (p < NP && ((fm >> p) & 1) == 1) r[61:60] = 2'd0;
        end
        return r;
    endfunction

    task automatic load_table(int variant);
        for (int i = 0; i < DEPTH; i++) begin
            if (i % 2 == 0) mem[i] = mk(0, 1'b0, i % 4, i + variant);
            else            mem[i] = mk(1 + 2 * (i % 4 == 1), 1'b0, i % 3, i + variant);
        end
        mem[0] = mk(1, 1'b0, 0, 11);     // unicast, port 0
        mem[1] = mk(3, 1'b0, 1, 12);     // unicast, port 1
        mem[2] = mk(1, 1'b1, 3'b011, 13); // multicast two externals
        mem[3] = mk(1, 1'b1, 3'b101, 14); // multicast port0 + host
        mem[4] = mk(3, 1'b1, 3'b110, 15); // multicast port1 + host
        mem[5] = mk(2, 1'b1, 3'b111, 16); // VLAN-only entry
        mem[6] = mk(0, 1'b1, 3'b111, 17); // free entry
        mem[7] = mk(1, 1'b0, 2, 18);     // unicast owned by host
        mem[8] = mk(1, 1'b1, 3'b100, 19); // multicast host only
        mem[9] = mk(3, 1'b1, 3'b010, 20); // multicast port1 only
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = mem[i];
    endtask

    task automatic run_walk(int fm, int mid_start_at);
        ev_t ev;
        int  k;
        evq.delete();
        for (int i = 0; i < DEPTH; i++) begin
            ev = '{1, 0, i, '0, 0, 1, "R2"};
            evq.push_back(ev);
            ev = '{0, 0, 0, '0, 0, 1, "R2"};
            evq.push_back(ev);
            if (exp_mem[i][61:60] == 2'd1 || exp_mem[i][61:60] == 2'd3) begin
                exp_mem[i] = expect_entry(exp_mem[i], fm);
                ev = '{1, 1, i, exp_mem[i], 0, 1, "R4"};
                evq.push_back(ev);
            end
        end
        ev = '{0, 0, 0, '0, 1, 1, "R9"};
        evq.push_back(ev);
        ev = '{0, 0, 0, '0, 0, 0, "R9"};
        evq.push_back(ev);

        @(negedge clk);
        start_i = 1'b1;
        flush_mask_i = NP'(fm);
        @(negedge clk);
        start_i = 1'b0;
        flush_mask_i = ~NP'(fm); // R10: later changes must not be taken
        k = 0;
        while (evq.size() > 0) begin
            ev = evq.pop_front();
            start_i = (k == mid_start_at);
            check(ev.tag, "busy", EW'(busy_o), EW'(ev.busy));
            check(ev.tag, "done", EW'(done_o), EW'(ev.done));
            check(ev.tag, "en", EW'(tbl_en_o), EW'(ev.en));
            if (ev.en) begin
                check(ev.tag, "we", EW'(tbl_we_o), EW'(ev.we));
                check(ev.tag, "addr", EW'(tbl_addr_o), EW'(ev.addr));
                if (ev.we) check(ev.tag, "wdata", tbl_wdata_o, ev.wd);
            end
            k++;
            @(negedge clk);
        end
        start_i = 1'b0;
        check("R10", "idle after walk", EW'(busy_o), EW'(0));
    endtask

    task automatic check_table(string tag);
        for (int i = 0; i < DEPTH; i++) check(tag, "table", mem[i], exp_mem[i]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "busy", EW'(busy_o), EW'(0));
        check("R1", "done", EW'(done_o), EW'(0));
        check("R1", "en", EW'(tbl_en_o), EW'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "en after reset", EW'(tbl_en_o), EW'(0));

        // R5 R6 R7: flush port 0
        load_table(0);
        run_walk(3'b001, -1);
        check_table("R5");
        check("R7", "mcast 101 freed", EW'(mem[3][61:60]), EW'(0));
        check("R7", "mcast 011 pruned", EW'(mem[2][68:66]), EW'(3'b010));
        check("R6", "mcast 110 untouched", mem[4], mk(3, 1'b1, 3'b110, 15));
        check("R3", "vlan entry untouched", mem[5], mk(2, 1'b1, 3'b111, 16));

        // R8: zero mask leaves every entry as it was
        load_table(1);
        run_walk(3'b000, -1);
        check_table("R8");

        // R7: all ports flushed; empty mask keeps its type. R10: restart attempt mid-walk
        load_table(2);
        run_walk(3'b111, 9);
        check_table("R7");
        check("R7", "empty mask keeps type", EW'(mem[2][61:60]), EW'(1));
        check("R5", "host unicast freed", EW'(mem[7][61:60]), EW'(0));

        // R5 R7: flush port 1
        load_table(3);
        run_walk(3'b010, 4);
        check_table("R5");
        check("R7", "mcast 110 freed", EW'(mem[4][61:60]), EW'(0));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule